// File: doc/BRIEF.md
# Half-Duplex Transmit Abort and Retry Controller

This block sits between the transmit FIFO of an Ethernet MAC and its nibble-wide transmit path. It watches each frame as it goes out and settles its fate. The frame can complete normally. A collision inside the slot window restarts it from its first nibble after a backoff delay. A collision after the window, or a FIFO that runs dry in mid-frame, cuts the frame short with a deliberately corrupted CRC. A frame that has collided on sixteen attempts in a row is thrown away without being sent.

The collision window is measured in transmit-clock cycles, one nibble per cycle, starting when the preamble begins. The default is 128 cycles (512 bit times). The backoff delay is a plain countdown that grows linearly with the attempt number. Each status event is a one-cycle pulse that can feed a sticky interrupt-event bit directly. Companion pulses ask the FIFO to rewind to the start of the frame or to flush what is left of it. In full-duplex mode the collision input has no effect.

Top module: `hdTxRetry`

## Requirements
- R1: After reset, txActive, slotCount, attemptCount and all six pulse outputs (restartReq, discardReq, forceBadCrc, evLateCol, evRetryLimit, evUnderrun) are 0.
- R2: When fifoStart is high while idle, txActive is 1 from the next cycle on. slotCount reads 0 in the first transmit cycle, rises by one per transmit cycle and stops at SLOT_NIBBLES.
- R3: When fifoValid and fifoEnd are high together in a transmit cycle, txActive drops in the next cycle, attemptCount returns to 0 and no status pulse or forceBadCrc is raised.
- R4: A collision in half-duplex mode in a transmit cycle with slotCount < SLOT_NIBBLES, when attemptCount < MAX_ATTEMPTS-1, has three effects. restartReq pulses in the next cycle and attemptCount rises by one to a value A. txActive then stays low for exactly A*BACKOFF_STEP+1 cycles, after which the frame restarts with slotCount 0.
- R5: A collision inside the window when attemptCount equals MAX_ATTEMPTS-1 (the sixteenth successive collision at default settings) drops the frame. evRetryLimit and discardReq pulse, and restartReq and forceBadCrc stay low. attemptCount returns to 0 and the block goes idle, ready to start the next frame with attemptCount 0.
- R6: A collision in half-duplex mode in a transmit cycle with slotCount equal to SLOT_NIBBLES is a late collision. evLateCol, forceBadCrc and discardReq pulse together, txActive drops and attemptCount returns to 0.
- R7: In a transmit cycle with fifoValid low and fifoEmpty high, the frame is an underrun. evUnderrun, forceBadCrc and discardReq pulse together, txActive drops and attemptCount returns to 0. If fifoValid is low but fifoEmpty is also low, the frame simply continues.
- R8: With fullDuplex high, the collision input is ignored. No restart, late-collision or retry-limit pulse is raised, and the frame continues.
- R9: A collision takes priority over an end of frame or an underrun seen in the same transmit cycle.
- R10: Every status pulse lasts a single cycle, and at most one of evLateCol, evRetryLimit and evUnderrun is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit nibble clock |
| rstN | input | 1 | Active-low synchronous reset |
| fifoStart | input | 1 | FIFO has a frame ready to start |
| fifoValid | input | 1 | FIFO delivers a nibble this cycle |
| fifoEnd | input | 1 | Current nibble is the last of the frame |
| fifoEmpty | input | 1 | FIFO holds no data |
| collision | input | 1 | Collision detected on the medium |
| fullDuplex | input | 1 | 1 = full duplex, 0 = half duplex |
| txActive | output | 1 | Frame attempt in progress |
| slotCount | output | $clog2(SLOT_NIBBLES+1) | Cycles since the start of the current attempt, saturating |
| attemptCount | output | $clog2(MAX_ATTEMPTS+1) | Collisions seen so far on the current frame |
| restartReq | output | 1 | Pulse: rewind the FIFO to the start of the frame |
| discardReq | output | 1 | Pulse: flush the rest of the frame from the FIFO |
| forceBadCrc | output | 1 | Pulse: tell the CRC generator to corrupt the CRC |
| evLateCol | output | 1 | Pulse: late collision |
| evRetryLimit | output | 1 | Pulse: frame dropped at the retry limit |
| evUnderrun | output | 1 | Pulse: transmit FIFO underrun |

## Verification
The bench uses a 16-cycle window. It injects a single collision at every slot position from 0 to 20. This separates restart from late collision right at the window edge, and each restart checks the exact length of the backoff gap. A sixteen-collision sequence shows that fifteen restarts happen, each with a longer gap than the last, and that the sixteenth collision drops the frame and lets the next one start clean. Underruns at several positions, FIFO gaps without the empty flag, full-duplex collisions, and collisions that coincide with an end of frame or an underrun separate the remaining outcomes and their priority.

// File: rtl/hdtx_pkg.sv
package hdtx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_TX      = 2'd1,
    ST_BACKOFF = 2'd2
  } txState_t;

  // control -> datapath
  typedef struct packed {
    logic startAttempt;
    logic advance;
    logic restart;
    logic dropLimit;
    logic lateCol;
    logic underrun;
    logic done;
  } strobes_t;

  // datapath -> control
  typedef struct packed {
    logic inWindow;
    logic lastAttempt;
    logic backoffZero;
  } pathStatus_t;

endpackage

// File: rtl/hdTxRetryCtrl.sv
module hdTxRetryCtrl
  import hdtx_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        fifoStart,
  input  logic        fifoValid,
  input  logic        fifoEnd,
  input  logic        fifoEmpty,
  input  logic        collision,
  input  logic        fullDuplex,
  input  pathStatus_t stat,
  output strobes_t    strb,
  output logic        txActive
);

  txState_t state, stateNext;
  logic     colEff;

  assign colEff   = collision & ~fullDuplex;
  assign txActive = (state == ST_TX);

  always_comb begin
    strb      = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (fifoStart) begin
          strb.startAttempt = 1'b1;
          stateNext         = ST_TX;
        end
      end
      ST_TX: begin
        if (colEff) begin
          if (!stat.inWindow) begin
            strb.lateCol = 1'b1;
            stateNext    = ST_IDLE;
          end else if (stat.lastAttempt) begin
            strb.dropLimit = 1'b1;
            stateNext      = ST_IDLE;
          end else begin
            strb.restart = 1'b1;
            stateNext    = ST_BACKOFF;
          end
        end else if (fifoValid && fifoEnd) begin
          strb.done = 1'b1;
          stateNext = ST_IDLE;
        end else if (!fifoValid && fifoEmpty) begin
          strb.underrun = 1'b1;
          stateNext     = ST_IDLE;
        end else begin
          strb.advance = 1'b1;
        end
      end
      ST_BACKOFF: begin
        if (stat.backoffZero) begin
          strb.startAttempt = 1'b1;
          stateNext         = ST_TX;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

endmodule

// File: rtl/hdTxRetryPath.sv
module hdTxRetryPath
  import hdtx_pkg::*;
#(
  parameter int SLOT_NIBBLES = 128,
  parameter int MAX_ATTEMPTS = 16,
  parameter int BACKOFF_STEP = 4,
  localparam int SLOT_W = $clog2(SLOT_NIBBLES + 1),
  localparam int ATT_W  = $clog2(MAX_ATTEMPTS + 1),
  localparam int BO_W   = $clog2(MAX_ATTEMPTS * BACKOFF_STEP + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  output pathStatus_t       stat,
  output logic [SLOT_W-1:0] slotCount,
  output logic [ATT_W-1:0]  attemptCount,
  output logic              restartReq,
  output logic              discardReq,
  output logic              forceBadCrc,
  output logic              evLateCol,
  output logic              evRetryLimit,
  output logic              evUnderrun
);

  logic [SLOT_W-1:0] slotCnt;
  logic [ATT_W-1:0]  attemptCnt;
  logic [BO_W-1:0]   backoffCnt;
  logic              frameExit;

  assign frameExit = strb.done | strb.lateCol | strb.underrun | strb.dropLimit;

  assign stat.inWindow    = (slotCnt < SLOT_W'(SLOT_NIBBLES));
  assign stat.lastAttempt = (attemptCnt == ATT_W'(MAX_ATTEMPTS - 1));
  assign stat.backoffZero = (backoffCnt == '0);

  // slot-window counter, saturating at the window length
  always_ff @(posedge clk) begin
    if (!rstN)
      slotCnt <= '0;
    else if (strb.startAttempt || frameExit || strb.restart)
      slotCnt <= '0;
    else if (strb.advance && slotCnt != SLOT_W'(SLOT_NIBBLES))
      slotCnt <= slotCnt + 1'b1;
  end

  // attempt counter
  always_ff @(posedge clk) begin
    if (!rstN)              attemptCnt <= '0;
    else if (frameExit)     attemptCnt <= '0;
    else if (strb.restart)  attemptCnt <= attemptCnt + 1'b1;
  end

  // linear backoff countdown
  always_ff @(posedge clk) begin
    if (!rstN)
      backoffCnt <= '0;
    else if (strb.restart)
      backoffCnt <= BO_W'((int'(attemptCnt) + 1) * BACKOFF_STEP);
    else if (backoffCnt != '0)
      backoffCnt <= backoffCnt - 1'b1;
  end

  // registered pulses
  always_ff @(posedge clk) begin
    if (!rstN) begin
      restartReq   <= 1'b0;
      discardReq   <= 1'b0;
      forceBadCrc  <= 1'b0;
      evLateCol    <= 1'b0;
      evRetryLimit <= 1'b0;
      evUnderrun   <= 1'b0;
    end else begin
      restartReq   <= strb.restart;
      discardReq   <= strb.lateCol | strb.underrun | strb.dropLimit;
      forceBadCrc  <= strb.lateCol | strb.underrun;
      evLateCol    <= strb.lateCol;
      evRetryLimit <= strb.dropLimit;
      evUnderrun   <= strb.underrun;
    end
  end

  assign slotCount    = slotCnt;
  assign attemptCount = attemptCnt;

endmodule

// File: rtl/hdTxRetry.sv
module hdTxRetry
  import hdtx_pkg::*;
#(
  parameter int SLOT_NIBBLES = 128,
  parameter int MAX_ATTEMPTS = 16,
  parameter int BACKOFF_STEP = 4,
  localparam int SLOT_W = $clog2(SLOT_NIBBLES + 1),
  localparam int ATT_W  = $clog2(MAX_ATTEMPTS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fifoStart,
  input  logic              fifoValid,
  input  logic              fifoEnd,
  input  logic              fifoEmpty,
  input  logic              collision,
  input  logic              fullDuplex,
  output logic              txActive,
  output logic [SLOT_W-1:0] slotCount,
  output logic [ATT_W-1:0]  attemptCount,
  output logic              restartReq,
  output logic              discardReq,
  output logic              forceBadCrc,
  output logic              evLateCol,
  output logic              evRetryLimit,
  output logic              evUnderrun
);

  strobes_t    strb;
  pathStatus_t stat;

  hdTxRetryCtrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .fifoStart(fifoStart), .fifoValid(fifoValid), .fifoEnd(fifoEnd),
    .fifoEmpty(fifoEmpty), .collision(collision), .fullDuplex(fullDuplex),
    .stat(stat), .strb(strb), .txActive(txActive)
  );

  hdTxRetryPath #(
    .SLOT_NIBBLES(SLOT_NIBBLES),
    .MAX_ATTEMPTS(MAX_ATTEMPTS),
    .BACKOFF_STEP(BACKOFF_STEP)
  ) path_i (
    .clk(clk), .rstN(rstN), .strb(strb), .stat(stat),
    .slotCount(slotCount), .attemptCount(attemptCount),
    .restartReq(restartReq), .discardReq(discardReq), .forceBadCrc(forceBadCrc),
    .evLateCol(evLateCol), .evRetryLimit(evRetryLimit), .evUnderrun(evUnderrun)
  );

endmodule

// File: rtl/hdTxRetryChk.sv
module hdTxRetryChk #(
  parameter int SLOT_NIBBLES = 128,
  parameter int MAX_ATTEMPTS = 16,
  localparam int SLOT_W = $clog2(SLOT_NIBBLES + 1),
  localparam int ATT_W  = $clog2(MAX_ATTEMPTS + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              fullDuplex,
  input logic              txActive,
  input logic [SLOT_W-1:0] slotCount,
  input logic [ATT_W-1:0]  attemptCount,
  input logic              restartReq,
  input logic              discardReq,
  input logic              forceBadCrc,
  input logic              evLateCol,
  input logic              evRetryLimit,
  input logic              evUnderrun
);

  p_slot_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(txActive) && txActive && $past(slotCount) < SLOT_W'(SLOT_NIBBLES))
      |-> slotCount == SLOT_W'($past(slotCount) + 1'b1));

  p_slot_cap_r2: assert property (@(posedge clk) disable iff (!rstN)
    slotCount <= SLOT_W'(SLOT_NIBBLES));

  p_restart_count_r4: assert property (@(posedge clk) disable iff (!rstN)
    restartReq |-> (attemptCount == ATT_W'($past(attemptCount) + 1'b1)) && !txActive);

  p_limit_drop_r5: assert property (@(posedge clk) disable iff (!rstN)
    evRetryLimit |-> discardReq && !forceBadCrc && !restartReq && attemptCount == '0);

  p_late_badcrc_r6: assert property (@(posedge clk) disable iff (!rstN)
    evLateCol |-> forceBadCrc && discardReq && !txActive);

  p_underrun_badcrc_r7: assert property (@(posedge clk) disable iff (!rstN)
    evUnderrun |-> forceBadCrc && discardReq && !txActive);

  p_fdx_ignore_r8: assert property (@(posedge clk) disable iff (!rstN)
    $past(fullDuplex) |-> !restartReq && !evLateCol && !evRetryLimit);

  p_one_event_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({evLateCol, evRetryLimit, evUnderrun}));

  p_pulse_late_r10: assert property (@(posedge clk) disable iff (!rstN)
    evLateCol |=> !evLateCol);

  p_pulse_limit_r10: assert property (@(posedge clk) disable iff (!rstN)
    evRetryLimit |=> !evRetryLimit);

  p_pulse_under_r10: assert property (@(posedge clk) disable iff (!rstN)
    evUnderrun |=> !evUnderrun);

endmodule

bind hdTxRetry hdTxRetryChk #(
  .SLOT_NIBBLES(SLOT_NIBBLES),
  .MAX_ATTEMPTS(MAX_ATTEMPTS)
) chk_i (
  .clk(clk), .rstN(rstN), .fullDuplex(fullDuplex), .txActive(txActive),
  .slotCount(slotCount), .attemptCount(attemptCount),
  .restartReq(restartReq), .discardReq(discardReq), .forceBadCrc(forceBadCrc),
  .evLateCol(evLateCol), .evRetryLimit(evRetryLimit), .evUnderrun(evUnderrun)
);

// File: tb/hdTxRetry_tb.sv
module hdTxRetry_tb_top;

  localparam int SLOT   = 16;
  localparam int MAXA   = 16;
  localparam int STEP   = 2;
  localparam int SLOT_W = $clog2(SLOT + 1);
  localparam int ATT_W  = $clog2(MAXA + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fifoStart = 1'b0, fifoValid = 1'b0, fifoEnd = 1'b0, fifoEmpty = 1'b0;
  logic collision = 1'b0, fullDuplex = 1'b0;
  logic txActive, restartReq, discardReq, forceBadCrc;
  logic evLateCol, evRetryLimit, evUnderrun;
  logic [SLOT_W-1:0] slotCount;
  logic [ATT_W-1:0]  attemptCount;

  int vectors = 0;
  int fails   = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  hdTxRetry #(.SLOT_NIBBLES(SLOT), .MAX_ATTEMPTS(MAXA), .BACKOFF_STEP(STEP)) dut_i (
    .clk(clk), .rstN(rstN),
    .fifoStart(fifoStart), .fifoValid(fifoValid), .fifoEnd(fifoEnd), .fifoEmpty(fifoEmpty),
    .collision(collision), .fullDuplex(fullDuplex),
    .txActive(txActive), .slotCount(slotCount), .attemptCount(attemptCount),
    .restartReq(restartReq), .discardReq(discardReq), .forceBadCrc(forceBadCrc),
    .evLateCol(evLateCol), .evRetryLimit(evRetryLimit), .evUnderrun(evUnderrun)
  );

  task automatic chk(string req, int act, int exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic int pulses();
    return {restartReq, discardReq, forceBadCrc, evLateCol, evRetryLimit, evUnderrun};
  endfunction

  function automatic int minSlot(int i);
    return (i < SLOT) ? i : SLOT;
  endfunction

  // begin a frame; on return the first transmit cycle is visible
  task automatic startFrame(string req);
    fifoStart = 1'b1; fifoValid = 1'b1; fifoEmpty = 1'b0;
    tick();
    fifoStart = 1'b0;
    chk({req, " txActive on start"}, int'(txActive), 1);
    chk({req, " slotCount on start"}, int'(slotCount), 0);
  endtask

  // advance from slot position 'from' to 'to', checking the count each cycle (R2)
  task automatic advanceTo(int from, int to);
    for (int i = from + 1; i <= to; i++) begin
      tick();
      chk("R2 slotCount step", int'(slotCount), minSlot(i));
    end
  endtask

  task automatic endFrame(string req);
    fifoEnd = 1'b1;
    tick();
    fifoEnd = 1'b0;
    chk({req, " R3 txActive after end"}, int'(txActive), 0);
    chk({req, " R3 attempt cleared"}, int'(attemptCount), 0);
    chk({req, " R3 no pulses"}, pulses(), 0);
  endtask

  task automatic backoffCheck(int newAtt);
    int lowCnt = 0;
    while (!txActive && lowCnt < 1000) begin
      lowCnt++;
      tick();
    end
    chk("R4 backoff gap", lowCnt, newAtt * STEP + 1);
    chk("R4 restart slotCount", int'(slotCount), 0);
    chk("R4 attempt held", int'(attemptCount), newAtt);
  endtask

  task automatic hitCollision();
    collision = 1'b1;
    tick();
    collision = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    // R1 reset state
    chk("R1 txActive", int'(txActive), 0);
    chk("R1 slotCount", int'(slotCount), 0);
    chk("R1 attemptCount", int'(attemptCount), 0);
    chk("R1 pulses", pulses(), 0);

    // R2/R3 normal frame longer than the window
    startFrame("R2");
    advanceTo(0, 40);
    endFrame("R3 long");

    // R4/R6 single collision at each position 0..20
    for (int p = 0; p <= 20; p++) begin
      startFrame("R4");
      advanceTo(0, p);
      hitCollision();
      if (minSlot(p) < SLOT) begin
        chk("R4 restartReq", int'(restartReq), 1);
        chk("R4 no bad crc", int'(forceBadCrc), 0);
        chk("R4 attempt", int'(attemptCount), 1);
        chk("R4 txActive low", int'(txActive), 0);
        backoffCheck(1);
        endFrame("R4 finish");
      end else begin
        chk("R6 evLateCol", int'(evLateCol), 1);
        chk("R6 forceBadCrc", int'(forceBadCrc), 1);
        chk("R6 discardReq", int'(discardReq), 1);
        chk("R6 txActive", int'(txActive), 0);
        chk("R6 attempt", int'(attemptCount), 0);
        tick();
        chk("R10 pulse ends", pulses(), 0);
      end
    end

    // R5 sixteen successive collisions
    startFrame("R5");
    for (int k = 1; k <= MAXA; k++) begin
      advanceTo(0, 2);
      hitCollision();
      if (k < MAXA) begin
        chk("R4 restart in sequence", int'(restartReq), 1);
        chk("R4 attempt in sequence", int'(attemptCount), k);
        backoffCheck(k);
      end else begin
        chk("R5 evRetryLimit", int'(evRetryLimit), 1);
        chk("R5 discardReq", int'(discardReq), 1);
        chk("R5 no restart", int'(restartReq), 0);
        chk("R5 no bad crc", int'(forceBadCrc), 0);
        chk("R5 attempt cleared", int'(attemptCount), 0);
        chk("R5 idle", int'(txActive), 0);
      end
    end
    tick();
    chk("R10 limit pulse ends", pulses(), 0);
    startFrame("R5 next frame");
    chk("R5 next attempt", int'(attemptCount), 0);
    advanceTo(0, 5);
    endFrame("R5 next");

    // R7 underrun at several positions, plus gap without empty
    for (int q = 0; q < 3; q++) begin
      int p = (q == 0) ? 0 : (q == 1) ? 5 : 20;
      startFrame("R7");
      advanceTo(0, p);
      fifoValid = 1'b0; fifoEmpty = 1'b0;
      tick();
      chk("R7 gap keeps frame", int'(txActive), 1);
      chk("R7 gap no underrun", int'(evUnderrun), 0);
      chk("R7 gap slotCount", int'(slotCount), minSlot(p + 1));
      fifoEmpty = 1'b1;
      tick();
      fifoValid = 1'b1; fifoEmpty = 1'b0;
      chk("R7 evUnderrun", int'(evUnderrun), 1);
      chk("R7 forceBadCrc", int'(forceBadCrc), 1);
      chk("R7 discardReq", int'(discardReq), 1);
      chk("R7 txActive", int'(txActive), 0);
      tick();
      chk("R10 underrun pulse ends", pulses(), 0);
    end

    // R8 full duplex ignores collisions
    fullDuplex = 1'b1;
    startFrame("R8");
    advanceTo(0, 3);
    hitCollision();
    chk("R8 early ignored", int'(txActive), 1);
    chk("R8 early no pulses", pulses(), 0);
    advanceTo(4, 20);
    hitCollision();
    chk("R8 late ignored", int'(txActive), 1);
    chk("R8 late no pulses", pulses(), 0);
    endFrame("R8");
    fullDuplex = 1'b0;

    // R9 collision beats end and underrun
    startFrame("R9");
    advanceTo(0, 3);
    fifoEnd = 1'b1;
    hitCollision();
    fifoEnd = 1'b0;
    chk("R9 restart over end", int'(restartReq), 1);
    backoffCheck(1);
    endFrame("R9 a");
    startFrame("R9");
    advanceTo(0, 18);
    fifoValid = 1'b0; fifoEmpty = 1'b1;
    hitCollision();
    fifoValid = 1'b1; fifoEmpty = 1'b0;
    chk("R9 late over underrun", int'(evLateCol), 1);
    chk("R9 no underrun", int'(evUnderrun), 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule